// File: doc/BRIEF.md
# Banked Serial Register File

This block is a four-wire serial slave (chip select, serial clock, data in, data out) in front of two banks of 10-bit configuration registers. A host sends 16-bit frames with the most significant bit first. A frame holds a read/write flag, a 5-bit register address and a 10-bit data word. Writes are held back until chip select returns high, and only a frame of exactly 16 clocks commits. Reads return the addressed word on the data-out line, one bit per falling serial clock edge, as soon as the address is complete.

One bit of main register 0 chooses whether addresses 1 to 31 refer to the main bank or to the local bank. Address 0 always reaches main register 0, so the host can switch back from either bank. Two main registers can be read back as live status instead of their stored contents. When a select bit in main register 27 is set, register 19 returns a tune ADC code and a VCO sub-band, and register 21 returns a revision code.

The serial pins are oversampled by the system clock through a synchronizer, so the serial clock must be several times slower than the system clock. The register arrays have no reset. The host must load them after power-up. Every stored word is presented on flat configuration outputs for the rest of the chip.

Top module: `spi_banked_regfile`

## Requirements
- R1: A frame is 16 bits, MSB first: bit 15 is the read/write flag (0 = write, 1 = read), bits 14:10 are the address and bits 9:0 are the data. A write frame stores its data in the addressed register, and that register's slice of the configuration output then shows the data.
- R2: A write takes effect only after chip select rises. While chip select stays low after the 16th clock, the configuration outputs keep their old value.
- R3: A frame with fewer or more than 16 rising serial clock edges before chip select rises changes no register.
- R4: In a read frame, the data-out line changes on falling serial clock edges. The falling edge after the 6th rising edge presents data bit 9, and each later falling edge presents the next lower bit, down to bit 0.
- R5: Bit 0 of main register 0 selects the bank for addresses 1 to 31: 0 = main, 1 = local. The same address in the two banks holds independent words.
- R6: Address 0 always reads and writes main register 0, whichever bank is selected. Local slot 0 does not exist, and its configuration slice reads 0.
- R7: In the main bank, with bit 5 of main register 27 set, a read of register 19 returns bit 9 = 0, bits 8:6 = tune ADC input and bits 5:0 = sub-band input. With that bit clear, the read returns the stored word.
- R8: In the main bank, with bit 9 of main register 27 set, a read of register 21 returns bits 7:5 = revision input and all other bits 0. With that bit clear, the read returns the stored word.
- R9: While the local bank is selected, reads of addresses 19 and 21 return the stored local words, whatever main register 27 holds.
- R10: A read frame changes no register. The data-out line is 0 after reset and whenever chip select is high.
- R11: The reset input clears only the serial frame logic. Register contents survive a reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the serial pins |
| rst_n | input | 1 | Active-low reset of the frame logic |
| spi_csn_i | input | 1 | Active-low chip select |
| spi_sclk_i | input | 1 | Serial clock |
| spi_din_i | input | 1 | Serial data in |
| spi_dout_o | output | 1 | Serial data out |
| tune_adc_i | input | 3 | Live tune ADC code for the register 19 overlay |
| sub_band_i | input | 6 | Live VCO sub-band for the register 19 overlay |
| rev_id_i | input | 3 | Revision code for the register 21 overlay |
| main_cfg_o | output | 320 | Main bank words, register n at bits n*10+9:n*10 |
| local_cfg_o | output | 320 | Local bank words, same layout, slot 0 reads 0 |

## Verification
Directed frames compare a well-formed 16-clock write with frames cut short at 15 clocks or run on to 17 clocks. This shows that only the exact count commits. A write whose chip select is held low after the last clock shows that storage waits for the chip-select edge. Reads of the same address are taken in the main bank, in the local bank and at address 0 after a bank switch, with the overlay selects set and clear. These reads tell apart bank routing, address-0 aliasing and status substitution. A constrained-random mix of writes and reads over all addresses, including random bank flips through address 0 and changing status inputs, is then compared against a bench model.

// File: rtl/spi_banked_regfile_pkg.sv
package spi_banked_regfile_pkg;
    localparam int RF_DATA_W   = 10;
    localparam int RF_ADDR_W   = 5;
    // overlay and bank-select positions decoded by the read path
    localparam int BANK_BIT    = 0;
    localparam int OVL_CTRL    = 27;
    localparam int VCO_OVL_BIT = 5;
    localparam int DIE_OVL_BIT = 9;
    localparam int VCO_ADDR    = 19;
    localparam int DIE_ADDR    = 21;
    localparam int ADC_W       = 3;
    localparam int BAND_W      = 6;
    localparam int REV_W       = 3;
    localparam int REV_LSB     = 5;
endpackage

// File: rtl/spi_banked_sync.sv
module spi_banked_sync #(
    parameter int          W      = 3,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_V = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_V;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_banked_frame.sv
module spi_banked_frame #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 10,
    localparam int FRAME_W = 1 + ADDR_W + DATA_W,
    localparam int HDR_W   = 1 + ADDR_W,
    localparam int CNT_W   = $clog2(FRAME_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              dout,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              cs_rise,
    output logic              cs_fall,
    output logic              sclk_fall,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W - 1);

    typedef struct packed {
        logic               cs_prev;
        logic               sclk_prev;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shift;
        logic               load_pend;
        logic               reading;
        logic [DATA_W-1:0]  rd_sh;
        logic               dout;
        logic               wr_en;
        logic [ADDR_W-1:0]  wr_addr;
        logic [DATA_W-1:0]  wr_data;
    } frame_t;

    frame_t q, d;
    logic sclk_rise;

    always_comb begin
        d           = q;
        d.wr_en     = 1'b0;
        d.load_pend = 1'b0;
        d.cs_prev   = csn_s;
        d.sclk_prev = sclk_s;

        cs_fall   = q.cs_prev & ~csn_s;
        cs_rise   = ~q.cs_prev & csn_s;
        sclk_rise = ~q.sclk_prev & sclk_s & ~csn_s;
        sclk_fall = q.sclk_prev & ~sclk_s & ~csn_s;

        if (cs_fall) begin
            d.cnt     = '0;
            d.shift   = '0;
            d.reading = 1'b0;
            d.dout    = 1'b0;
        end else if (!csn_s) begin
            if (sclk_rise) begin
                d.shift = {q.shift[FRAME_W-2:0], din_s};
                if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_HDR) d.load_pend = 1'b1;
            end
            if (q.load_pend && q.shift[ADDR_W]) begin
                d.reading = 1'b1;
                d.rd_sh   = rd_data;
            end
            if (sclk_fall && q.reading) begin
                d.dout  = q.rd_sh[DATA_W-1];
                d.rd_sh = {q.rd_sh[DATA_W-2:0], 1'b0};
            end
        end

        if (cs_rise) begin
            d.reading = 1'b0;
            d.dout    = 1'b0;
            if (q.cnt == CNT_FULL && !q.shift[FRAME_W-1]) begin
                d.wr_en   = 1'b1;
                d.wr_addr = q.shift[FRAME_W-2 -: ADDR_W];
                d.wr_data = q.shift[DATA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.cs_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.shift[ADDR_W-1:0];
    assign dout    = q.dout;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign bit_cnt = q.cnt;
endmodule

// File: rtl/spi_banked_store.sv
module spi_banked_store
    import spi_banked_regfile_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 10,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [ADC_W-1:0]       tune_adc,
    input  logic [BAND_W-1:0]      sub_band,
    input  logic [REV_W-1:0]       rev_id,
    output logic [DATA_W-1:0]      rd_data,
    output logic [NREG*DATA_W-1:0] main_flat,
    output logic [NREG*DATA_W-1:0] local_flat
);
    typedef logic [DATA_W-1:0] word_t;

    word_t main_q [NREG];
    word_t main_d [NREG];
    word_t loc_q  [NREG];
    word_t loc_d  [NREG];

    logic  bank_local;
    logic  vco_ovl;
    logic  die_ovl;

    assign bank_local = main_q[0][BANK_BIT];
    assign vco_ovl    = main_q[OVL_CTRL][VCO_OVL_BIT];
    assign die_ovl    = main_q[OVL_CTRL][DIE_OVL_BIT];

    // write path: address 0 is always main register 0
    always_comb begin
        main_d   = main_q;
        loc_d    = loc_q;
        loc_d[0] = '0;
        if (wr_en) begin
            if (wr_addr == '0)  main_d[0]       = wr_data;
            else if (bank_local) loc_d[wr_addr]  = wr_data;
            else                 main_d[wr_addr] = wr_data;
        end
    end

    // storage has no reset: contents must be loaded by the host
    always_ff @(posedge clk) begin
        main_q <= main_d;
        loc_q  <= loc_d;
    end

    // read path with status overlays in the main bank only
    always_comb begin
        rd_data = main_q[rd_addr];
        if (rd_addr == '0) begin
            rd_data = main_q[0];
        end else if (bank_local) begin
            rd_data = loc_q[rd_addr];
        end else if (rd_addr == ADDR_W'(VCO_ADDR) && vco_ovl) begin
            rd_data = '0;
            rd_data[BAND_W-1:0]            = sub_band;
            rd_data[BAND_W +: ADC_W]       = tune_adc;
        end else if (rd_addr == ADDR_W'(DIE_ADDR) && die_ovl) begin
            rd_data = '0;
            rd_data[REV_LSB +: REV_W]      = rev_id;
        end
    end

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_flat
            assign main_flat[i*DATA_W +: DATA_W] = main_q[i];
            if (i == 0) begin : g_l0
                assign local_flat[i*DATA_W +: DATA_W] = '0;
            end else begin : g_ln
                assign local_flat[i*DATA_W +: DATA_W] = loc_q[i];
            end
        end
    endgenerate
endmodule

// File: rtl/spi_banked_regfile.sv
module spi_banked_regfile
    import spi_banked_regfile_pkg::*;
#(
    parameter int ADDR_W      = RF_ADDR_W,
    parameter int DATA_W      = RF_DATA_W,
    parameter int SYNC_STAGES = 2,
    localparam int NREG       = 1 << ADDR_W,
    localparam int FRAME_W    = 1 + ADDR_W + DATA_W,
    localparam int CNT_W      = $clog2(FRAME_W + 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_csn_i,
    input  logic                   spi_sclk_i,
    input  logic                   spi_din_i,
    output logic                   spi_dout_o,
    input  logic [ADC_W-1:0]       tune_adc_i,
    input  logic [BAND_W-1:0]      sub_band_i,
    input  logic [REV_W-1:0]       rev_id_i,
    output logic [NREG*DATA_W-1:0] main_cfg_o,
    output logic [NREG*DATA_W-1:0] local_cfg_o
);
    logic [2:0]        pins_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              cs_rise;
    logic              cs_fall;
    logic              sclk_fall;
    logic [CNT_W-1:0]  bit_cnt;

    spi_banked_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_V  (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_csn_i, spi_sclk_i, spi_din_i}),
        .sync_o  (pins_s)
    );

    spi_banked_frame #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .csn_s     (pins_s[2]),
        .sclk_s    (pins_s[1]),
        .din_s     (pins_s[0]),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .dout      (spi_dout_o),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cs_rise   (cs_rise),
        .cs_fall   (cs_fall),
        .sclk_fall (sclk_fall),
        .bit_cnt   (bit_cnt)
    );

    spi_banked_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk        (clk),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .tune_adc   (tune_adc_i),
        .sub_band   (sub_band_i),
        .rev_id     (rev_id_i),
        .rd_data    (rd_data),
        .main_flat  (main_cfg_o),
        .local_flat (local_cfg_o)
    );
endmodule

// File: rtl/spi_banked_regfile_chk.sv
module spi_banked_regfile_chk #(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 10,
    parameter int NREG    = 32,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      wr_addr,
    input logic [DATA_W-1:0]      wr_data,
    input logic                   cs_rise,
    input logic                   cs_fall,
    input logic                   sclk_fall,
    input logic [CNT_W-1:0]       bit_cnt,
    input logic                   spi_dout_o,
    input logic [NREG*DATA_W-1:0] main_cfg_o,
    input logic [NREG*DATA_W-1:0] local_cfg_o
);
    AST_WRITE_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(cs_rise)); // R2

    AST_WRITE_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(bit_cnt) == CNT_W'(FRAME_W))); // R3

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(main_cfg_o) && $stable(local_cfg_o))); // R1

    AST_ADDR0_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (main_cfg_o[DATA_W-1:0] == $past(wr_data))); // R6

    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !cs_rise && !cs_fall) |=> $stable(spi_dout_o)); // R4
endmodule

bind spi_banked_regfile spi_banked_regfile_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NREG    (NREG),
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .cs_rise     (cs_rise),
    .cs_fall     (cs_fall),
    .sclk_fall   (sclk_fall),
    .bit_cnt     (bit_cnt),
    .spi_dout_o  (spi_dout_o),
    .main_cfg_o  (main_cfg_o),
    .local_cfg_o (local_cfg_o)
);

// File: tb/spi_banked_regfile_bench.sv
`timescale 1ns/1ps
module spi_banked_regfile_bench;
    localparam int HALF = 6;
    localparam int WD   = 190000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         csn = 1'b1;
    logic         sclk = 1'b0;
    logic         din = 1'b0;
    logic         dout;
    logic [2:0]   adc = '0;
    logic [5:0]   band = '0;
    logic [2:0]   rev = '0;
    logic [319:0] main_cfg;
    logic [319:0] local_cfg;

    int total = 0;
    int fails = 0;

    logic [9:0] mm [32];
    logic [9:0] lm [32];

    always #2.5 clk = ~clk;

    spi_banked_regfile u_spi_banked_regfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_csn_i   (csn),
        .spi_sclk_i  (sclk),
        .spi_din_i   (din),
        .spi_dout_o  (dout),
        .tune_adc_i  (adc),
        .sub_band_i  (band),
        .rev_id_i    (rev),
        .main_cfg_o  (main_cfg),
        .local_cfg_o (local_cfg)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic logic [9:0] exp_read(input int a);
        logic [9:0] r;
        if (a == 0)                       r = mm[0];
        else if (mm[0][0])                r = lm[a];
        else if (a == 19 && mm[27][5])    r = {1'b0, adc, band};
        else if (a == 21 && mm[27][9])    r = {2'b00, rev, 5'b00000};
        else                              r = mm[a];
        return r;
    endfunction

    function automatic void model_write(input int a, input logic [9:0] v);
        if (a == 0)        mm[0] = v;
        else if (mm[0][0]) lm[a] = v;
        else               mm[a] = v;
    endfunction

    task automatic xfer(input bit rw, input int a, input logic [9:0] v,
                        input int nbits, input bit hold, output logic [9:0] rd);
        logic [15:0] fr;
        fr  = {rw, a[4:0], v};
        rd  = '0;
        csn = 1'b0;
        tick(HALF);
        for (int b = 0; b < nbits; b++) begin
            din  = (b < 16) ? fr[15-b] : 1'b0;
            sclk = 1'b0;
            tick(HALF);
            if (b >= 6 && b < 16) rd[15-b] = dout;
            sclk = 1'b1;
            tick(HALF);
        end
        sclk = 1'b0;
        tick(HALF);
        if (!hold) begin
            csn = 1'b1;
            tick(HALF);
        end
    endtask

    task automatic wr(input int a, input logic [9:0] v);
        logic [9:0] rd;
        xfer(1'b0, a, v, 16, 1'b0, rd);
        model_write(a, v);
    endtask

    task automatic rd_check(input int a, input string req);
        logic [9:0] rd;
        logic [9:0] e;
        e = exp_read(a);
        xfer(1'b1, a, 10'h0, 16, 1'b0, rd);
        check(rd === e, req, int'(rd), int'(e));
    endtask

    function automatic logic [9:0] mcfg(input int a);
        return main_cfg[a*10 +: 10];
    endfunction

    function automatic logic [9:0] lcfg(input int a);
        return local_cfg[a*10 +: 10];
    endfunction

    initial begin
        repeat (WD) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog R1 got=timeout exp=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [9:0] rd;
        logic [319:0] snap;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 32; i++) begin
            mm[i] = '0;
            lm[i] = '0;
        end
        tick(10);
        rst_n = 1'b1;
        tick(10);
        check(dout === 1'b0, "R10 dout after reset", int'(dout), 0);

        // load both banks (no reset of contents)
        wr(0, 10'h000);
        for (int a = 1; a < 32; a++) wr(a, 10'($urandom) & 10'h1DF);
        wr(0, 10'h001);
        for (int a = 1; a < 32; a++) wr(a, 10'($urandom));
        wr(0, 10'h000);
        wr(27, 10'h000);

        // R1 basic write and readback
        wr(5, 10'h2A5);
        check(mcfg(5) === 10'h2A5, "R1 cfg slice", int'(mcfg(5)), 'h2A5);
        rd_check(5, "R1 readback");
        rd_check(5, "R4 readback bit order");
        check(dout === 1'b0, "R10 dout idle", int'(dout), 0);

        // R2 write waits for chip select rise
        xfer(1'b0, 6, 10'h155, 16, 1'b1, rd);
        tick(20);
        check(mcfg(6) === mm[6], "R2 held cs", int'(mcfg(6)), int'(mm[6]));
        csn = 1'b1;
        tick(HALF);
        model_write(6, 10'h155);
        check(mcfg(6) === 10'h155, "R2 after cs rise", int'(mcfg(6)), 'h155);

        // R3 malformed frames
        xfer(1'b0, 7, 10'h3C3, 15, 1'b0, rd);
        check(mcfg(7) === mm[7], "R3 short frame", int'(mcfg(7)), int'(mm[7]));
        xfer(1'b0, 7, 10'h3C3, 17, 1'b0, rd);
        check(mcfg(7) === mm[7], "R3 long frame", int'(mcfg(7)), int'(mm[7]));
        rd_check(7, "R3 readback");

        // R5 banks independent
        wr(0, 10'h001);
        wr(5, 10'h0F0);
        check(lcfg(5) === 10'h0F0, "R5 local slice", int'(lcfg(5)), 'h0F0);
        check(mcfg(5) === 10'h2A5, "R5 main untouched", int'(mcfg(5)), 'h2A5);
        rd_check(5, "R5 local read");

        // R6 address 0 from local bank
        check(lcfg(0) === 10'h000, "R6 local slot0", int'(lcfg(0)), 0);
        rd_check(0, "R6 read addr0 in local");
        wr(0, 10'h000);
        check(mcfg(0) === 10'h000, "R6 main0 written", int'(mcfg(0)), 0);
        rd_check(5, "R6 back to main");

        // R7 VCO overlay
        adc = 3'd5; band = 6'h2B; rev = 3'd6;
        wr(27, 10'h020);
        rd_check(19, "R7 overlay on");
        wr(27, 10'h000);
        rd_check(19, "R7 overlay off");

        // R8 revision overlay
        wr(27, 10'h200);
        rd_check(21, "R8 overlay on");
        wr(27, 10'h220);

        // R9 no overlay in local bank
        wr(0, 10'h001);
        rd_check(19, "R9 local 19");
        rd_check(21, "R9 local 21");
        wr(0, 10'h000);
        rd_check(21, "R8 main 21 again");

        // R10 read changes nothing
        snap = main_cfg;
        xfer(1'b1, 9, 10'h3FF, 16, 1'b0, rd);
        check(main_cfg === snap, "R10 read no write", int'(main_cfg[99:90]), int'(snap[99:90]));
        check(dout === 1'b0, "R10 dout after read", int'(dout), 0);

        // R11 contents survive reset
        rst_n = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        rd_check(5, "R11 after reset");
        rd_check(6, "R11 after reset");

        // random mix
        for (int n = 0; n < 240; n++) begin
            int a;
            a = int'($urandom_range(0, 31));
            adc  = 3'($urandom);
            band = 6'($urandom);
            rev  = 3'($urandom);
            if ($urandom_range(0, 2) == 0) begin
                wr(a, 10'($urandom));
                check(mcfg(0) === mm[0], "R5 random bank reg", int'(mcfg(0)), int'(mm[0]));
            end else begin
                rd_check(a, "R1 random read");
            end
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule